// File: doc/BRIEF.md
# Eight-Bank Two-Port Cache Data Store

This block is the data storage of a cache. It holds word-wide data in eight independent single-ported banks and offers two access ports. Each port takes a byte address, a read/write flag, a transfer size, write data and a byte-order select. Consecutive 32-bit words go to different banks, so accesses to neighbouring words of a line do not collide. Two requests that select different banks both complete in the same cycle. When both ports select the same bank, port A wins and port B is held off through a ready signal.

Tag lookup, miss handling and line replacement live outside this block. Port B can also carry a maintenance request, flagged by a separate input. Such a request does not touch the banks. The store acknowledges it when port A is idle, and reports a scheduling error when port A is busy in the same cycle.

Top module: `qdp_bank_store`

## Requirements
- R1: The byte address splits into byte offset [1:0], bank index [4:2] and row [8:5]. A word written at any address reads back unchanged from that address through either port.
- R2: When port A and an ordinary port B request select different banks, `b_ready` is high and both requests complete in the same cycle.
- R3: When port A and an ordinary port B request select the same bank, `b_ready` is low and only port A is served. A port B request held for the next cycle with port A idle is then accepted.
- R4: Read data and `x_rvalid` appear in the cycle after a read is accepted. `x_rdata` is zero whenever `x_rvalid` is low.
- R5: Size encoding is 0 = byte, 1 = half-word, 2 and 3 = word. Write data is taken from the low bits of `x_wdata`, and read data is returned zero-extended in the low bits.
- R6: With `x_big_end` low, the byte at offset k occupies bits [8k+7:8k] of the stored word, and a half-word keeps its low byte at the lower address.
- R7: With `x_big_end` high, the byte at offset k occupies lane 3-k, so a half-word at offset 0 occupies bits [31:16] and a byte at offset 0 occupies bits [31:24].
- R8: A byte or half-word write changes only the lanes it covers. The other bytes of the word keep their value.
- R9: A half-word at an odd address, or a word whose address is not a multiple of 4, raises `x_misalign` in the next cycle. The access writes nothing and returns no read data.
- R10: A port B maintenance request (`b_special`) is never stalled and never touches the banks. With port A idle, `b_spec_ack` pulses in the next cycle.
- R11: A maintenance request while port A has a request raises `sched_err` in the next cycle instead of `b_spec_ack`. The port A access proceeds normally.
- R12: During reset, `a_rvalid`, `b_rvalid`, `a_misalign`, `b_misalign`, `b_spec_ack` and `sched_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Port A request |
| a_write | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A transfer size |
| a_addr | input | 9 | Port A byte address |
| a_wdata | input | 32 | Port A write data, low-aligned |
| a_big_end | input | 1 | Port A big-endian lane order |
| a_rdata | output | 32 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_misalign | output | 1 | Port A misaligned access flag |
| b_valid | input | 1 | Port B request |
| b_write | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B transfer size |
| b_addr | input | 9 | Port B byte address |
| b_wdata | input | 32 | Port B write data, low-aligned |
| b_big_end | input | 1 | Port B big-endian lane order |
| b_special | input | 1 | Port B maintenance request |
| b_ready | output | 1 | Port B request accepted this cycle |
| b_rdata | output | 32 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_misalign | output | 1 | Port B misaligned access flag |
| b_spec_ack | output | 1 | Maintenance request acknowledged |
| sched_err | output | 1 | Maintenance request issued while port A was busy |

## Verification
Two functions can fall in the same cycle: port A's bank access and port B's access to another bank, or port A's access and a port B maintenance request. The bench provokes the first pair with directed pairs of adjacent words and with random addresses, where collisions come up about one time in eight. In every cycle it compares `b_ready` with its own bank comparison, and it retries a stalled port B request with port A idle. For the second pair it issues maintenance requests with port A both idle and busy. It then judges `b_spec_ack` against `sched_err`, and checks that port A's read data in the same cycle is unaffected.

// File: rtl/qdp_pkg.sv
package qdp_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } xfer_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/qdp_port_align.sv
module qdp_port_align
  import qdp_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 4,
  localparam int ADDR_W = 2 + BANK_W + ROW_W
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              big_end,
  output logic              misalign,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wlane,
  output logic [4:0]        shift_bits,
  output logic [WORD_W-1:0] mask
);
  logic [1:0] off;
  logic [2:0] nbytes;
  logic [2:0] shift_bytes;
  logic [LANES-1:0] be_base;

  assign off  = addr[1:0];
  assign bank = addr[2 +: BANK_W];
  assign row  = addr[2 + BANK_W +: ROW_W];

  always_comb begin
    nbytes = size_bytes(size);
    case (size)
      SZ_BYTE: begin misalign = 1'b0;       be_base = 4'b0001; mask = 32'h0000_00FF; end
      SZ_HALF: begin misalign = off[0];     be_base = 4'b0011; mask = 32'h0000_FFFF; end
      default: begin misalign = (off != 2'd0); be_base = 4'b1111; mask = 32'hFFFF_FFFF; end
    endcase
    if (big_end) shift_bytes = 3'd4 - nbytes - {1'b0, off};
    else         shift_bytes = {1'b0, off};
    shift_bits = {shift_bytes[1:0], 3'b000};
    be         = misalign ? '0 : (be_base << shift_bytes[1:0]);
    wlane      = (wdata & mask) << shift_bits;
  end
endmodule

// File: rtl/qdp_arbiter.sv
module qdp_arbiter #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_valid,
  input  logic [BANK_W-1:0]    a_bank,
  input  logic                 b_valid,
  input  logic                 b_special,
  input  logic [BANK_W-1:0]    b_bank,
  output logic                 b_ready,
  output logic                 b_go,
  output logic                 spec_go,
  output logic [NUM_BANKS-1:0] a_sel,
  output logic [NUM_BANKS-1:0] b_sel
);
  logic clash;

  always_comb begin
    clash   = a_valid && b_valid && !b_special && (a_bank == b_bank);
    b_ready = !clash;
    b_go    = b_valid && !b_special && !clash;
    spec_go = b_valid && b_special;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign a_sel[i] = a_valid && (a_bank == BANK_W'(i));
    assign b_sel[i] = b_go    && (b_bank == BANK_W'(i));

    // R3: a bank is never driven by both ports in one cycle
    p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_sel[i] && b_sel[i]));
  end

  // R10: maintenance requests are never held off
  p_special_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_special) |-> b_ready);

  // R2: different banks never stall port B
  p_no_false_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && a_valid && (a_bank != b_bank)) |-> b_ready);
endmodule

// File: rtl/qdp_bank.sv
module qdp_bank
  import qdp_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) mem[row][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (en && !we) rdata <= mem[row];
  end

  // R8: a write always carries at least one lane
  p_write_has_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && we) |-> (be != '0));
endmodule

// File: rtl/qdp_bank_store.sv
module qdp_bank_store
  import qdp_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROWS      = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int ADDR_W   = 2 + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic              a_write,
  input  logic [1:0]        a_size,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [31:0]       a_wdata,
  input  logic              a_big_end,
  output logic [31:0]       a_rdata,
  output logic              a_rvalid,
  output logic              a_misalign,
  input  logic              b_valid,
  input  logic              b_write,
  input  logic [1:0]        b_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [31:0]       b_wdata,
  input  logic              b_big_end,
  input  logic              b_special,
  output logic              b_ready,
  output logic [31:0]       b_rdata,
  output logic              b_rvalid,
  output logic              b_misalign,
  output logic              b_spec_ack,
  output logic              sched_err
);
  // per-port alignment results
  logic              a_mis, b_mis;
  logic [BANK_W-1:0] a_bank, b_bank;
  logic [ROW_W-1:0]  a_row, b_row;
  logic [LANES-1:0]  a_be, b_be;
  logic [WORD_W-1:0] a_wl, b_wl, a_mask, b_mask;
  logic [4:0]        a_sh, b_sh;

  qdp_port_align #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_align_a (
    .size(a_size), .addr(a_addr), .wdata(a_wdata), .big_end(a_big_end),
    .misalign(a_mis), .bank(a_bank), .row(a_row), .be(a_be), .wlane(a_wl),
    .shift_bits(a_sh), .mask(a_mask));

  qdp_port_align #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_align_b (
    .size(b_size), .addr(b_addr), .wdata(b_wdata), .big_end(b_big_end),
    .misalign(b_mis), .bank(b_bank), .row(b_row), .be(b_be), .wlane(b_wl),
    .shift_bits(b_sh), .mask(b_mask));

  logic                 b_go, spec_go;
  logic [NUM_BANKS-1:0] a_sel, b_sel;

  qdp_arbiter #(.NUM_BANKS(NUM_BANKS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_bank(a_bank),
    .b_valid(b_valid), .b_special(b_special), .b_bank(b_bank),
    .b_ready(b_ready), .b_go(b_go), .spec_go(spec_go),
    .a_sel(a_sel), .b_sel(b_sel));

  logic [WORD_W-1:0] bank_rd [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic              en, we;
    logic [LANES-1:0]  be;
    logic [ROW_W-1:0]  row;
    logic [WORD_W-1:0] wd;

    always_comb begin
      en = a_sel[i] || b_sel[i];
      if (a_sel[i]) begin
        we = a_write && !a_mis; be = a_be; row = a_row; wd = a_wl;
      end else begin
        we = b_write && !b_mis; be = b_be; row = b_row; wd = b_wl;
      end
    end

    qdp_bank #(.ROWS(ROWS)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(en), .we(we), .be(be),
      .row(row), .wdata(wd), .rdata(bank_rd[i]));
  end

  // response next-state
  logic a_rv_d, a_mis_d, b_rv_d, b_mis_d, ack_d, err_d;

  always_comb begin
    a_rv_d  = a_valid && !a_write && !a_mis;
    a_mis_d = a_valid && a_mis;
    b_rv_d  = b_go && !b_write && !b_mis;
    b_mis_d = b_go && b_mis;
    ack_d   = spec_go && !a_valid;
    err_d   = spec_go && a_valid;
  end

  // response registers
  logic              a_rv_q, b_rv_q;
  logic [BANK_W-1:0] a_bank_q, b_bank_q;
  logic [4:0]        a_sh_q, b_sh_q;
  logic [WORD_W-1:0] a_mask_q, b_mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rv_q     <= 1'b0;
      b_rv_q     <= 1'b0;
      a_misalign <= 1'b0;
      b_misalign <= 1'b0;
      b_spec_ack <= 1'b0;
      sched_err  <= 1'b0;
    end else begin
      a_rv_q     <= a_rv_d;
      b_rv_q     <= b_rv_d;
      a_misalign <= a_mis_d;
      b_misalign <= b_mis_d;
      b_spec_ack <= ack_d;
      sched_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_bank_q <= '0; a_sh_q <= '0; a_mask_q <= '0;
    end else if (a_rv_d) begin
      a_bank_q <= a_bank; a_sh_q <= a_sh; a_mask_q <= a_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_bank_q <= '0; b_sh_q <= '0; b_mask_q <= '0;
    end else if (b_rv_d) begin
      b_bank_q <= b_bank; b_sh_q <= b_sh; b_mask_q <= b_mask;
    end
  end

  assign a_rvalid = a_rv_q;
  assign b_rvalid = b_rv_q;
  assign a_rdata  = a_rv_q ? ((bank_rd[a_bank_q] >> a_sh_q) & a_mask_q) : '0;
  assign b_rdata  = b_rv_q ? ((bank_rd[b_bank_q] >> b_sh_q) & b_mask_q) : '0;

  // R4: an aligned read on port A yields data next cycle
  p_read_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_write && !a_mis) |=> a_rvalid);

  // R9: a misaligned access flags and returns nothing
  p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_mis) |=> (a_misalign && !a_rvalid));

  // R10: maintenance with port A idle is acknowledged
  p_spec_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_special && !a_valid) |=> (b_spec_ack && !sched_err));

  // R11: maintenance with port A busy is a scheduling error
  p_sched_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_special && a_valid) |=> (sched_err && !b_spec_ack));

  // R4: port B output data is quiet without valid
  p_quiet_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rvalid |-> (b_rdata == '0));
endmodule

// File: tb/sim_qdp_bank_store.sv
`timescale 1ns/1ps
module sim_qdp_bank_store;
  localparam int AW = 9;
  localparam int NW = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, a_write, a_big_end;
  logic [1:0] a_size;
  logic [AW-1:0] a_addr;
  logic [31:0] a_wdata, a_rdata;
  logic a_rvalid, a_misalign;
  logic b_valid, b_write, b_big_end, b_special, b_ready;
  logic [1:0] b_size;
  logic [AW-1:0] b_addr;
  logic [31:0] b_wdata, b_rdata;
  logic b_rvalid, b_misalign, b_spec_ack, sched_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [NW];

  always #2.5 clk = ~clk;

  qdp_bank_store u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_write(a_write), .a_size(a_size), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_big_end(a_big_end), .a_rdata(a_rdata),
    .a_rvalid(a_rvalid), .a_misalign(a_misalign),
    .b_valid(b_valid), .b_write(b_write), .b_size(b_size), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_big_end(b_big_end), .b_special(b_special),
    .b_ready(b_ready), .b_rdata(b_rdata), .b_rvalid(b_rvalid),
    .b_misalign(b_misalign), .b_spec_ack(b_spec_ack), .sched_err(sched_err));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit is_mis(input logic [1:0] sz, input logic [AW-1:0] ad);
    return (sz == 2'd1 && ad[0]) || (sz[1] && ad[1:0] != 2'd0);
  endfunction

  // data byte j lives at address offset o; lane follows the byte order
  function automatic logic [31:0] get(input logic [31:0] w, input logic [1:0] sz,
                                      input logic [1:0] off, input bit big);
    logic [31:0] r = '0;
    int n = nb(sz);
    for (int j = 0; j < n; j++) begin
      int o  = big ? int'(off) + n - 1 - j : int'(off) + j;
      int ln = big ? 3 - o : o;
      r[8*j +: 8] = w[8*ln +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] put(input logic [31:0] w, input logic [31:0] d,
                                      input logic [1:0] sz, input logic [1:0] off, input bit big);
    logic [31:0] r = w;
    int n = nb(sz);
    for (int j = 0; j < n; j++) begin
      int o  = big ? int'(off) + n - 1 - j : int'(off) + j;
      int ln = big ? 3 - o : o;
      r[8*ln +: 8] = d[8*j +: 8];
    end
    return r;
  endfunction

  task automatic set_a(input bit v, input bit w, input logic [1:0] sz,
                       input logic [AW-1:0] ad, input logic [31:0] wd, input bit big);
    a_valid = v; a_write = w; a_size = sz; a_addr = ad; a_wdata = wd; a_big_end = big;
  endtask

  task automatic set_b(input bit v, input bit w, input logic [1:0] sz,
                       input logic [AW-1:0] ad, input logic [31:0] wd, input bit big, input bit sp);
    b_valid = v; b_write = w; b_size = sz; b_addr = ad; b_wdata = wd; b_big_end = big; b_special = sp;
  endtask

  // called just after a falling edge with inputs set; returns at the next falling edge
  task automatic run_cycle(output bit served);
    bit am, bm, conf, ea_v, eb_v, e_ack, e_err;
    logic [31:0] ea, eb;
    am   = is_mis(a_size, a_addr);
    bm   = is_mis(b_size, b_addr);
    conf = a_valid && b_valid && !b_special && (a_addr[4:2] == b_addr[4:2]);
    #1;
    if (conf) check(b_ready === 1'b0, "R3 b_ready", {31'd0, b_ready}, 32'd0);
    else      check(b_ready === 1'b1, "R2 b_ready", {31'd0, b_ready}, 32'd1);
    served = b_valid && !b_special && !conf;
    ea_v = a_valid && !a_write && !am;
    eb_v = served && !b_write && !bm;
    ea = ea_v ? get(mem[a_addr >> 2], a_size, a_addr[1:0], a_big_end) : '0;
    eb = eb_v ? get(mem[b_addr >> 2], b_size, b_addr[1:0], b_big_end) : '0;
    e_ack = b_valid && b_special && !a_valid;
    e_err = b_valid && b_special && a_valid;
    if (a_valid && a_write && !am)
      mem[a_addr >> 2] = put(mem[a_addr >> 2], a_wdata, a_size, a_addr[1:0], a_big_end);
    if (served && b_write && !bm)
      mem[b_addr >> 2] = put(mem[b_addr >> 2], b_wdata, b_size, b_addr[1:0], b_big_end);
    @(posedge clk);
    @(negedge clk);
    check(a_rvalid === ea_v, "R4 a_rvalid", {31'd0, a_rvalid}, {31'd0, ea_v});
    check(a_rdata === ea, "R4 a_rdata", a_rdata, ea);
    check(b_rvalid === eb_v, "R4 b_rvalid", {31'd0, b_rvalid}, {31'd0, eb_v});
    check(b_rdata === eb, "R4 b_rdata", b_rdata, eb);
    check(a_misalign === (a_valid && am), "R9 a_misalign", {31'd0, a_misalign}, {31'd0, a_valid && am});
    check(b_misalign === (served && bm), "R9 b_misalign", {31'd0, b_misalign}, {31'd0, served && bm});
    check(b_spec_ack === e_ack, "R10 b_spec_ack", {31'd0, b_spec_ack}, {31'd0, e_ack});
    check(sched_err === e_err, "R11 sched_err", {31'd0, sched_err}, {31'd0, e_err});
  endtask

  task automatic idle();
    set_a(0, 0, 2'd2, '0, '0, 0);
    set_b(0, 0, 2'd2, '0, '0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    bit s;
    int unsigned seed_use;
    seed_use = $urandom(32'd1357);
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: quiet outputs in reset
    check({a_rvalid, b_rvalid, a_misalign, b_misalign, b_spec_ack, sched_err} === 6'b0,
          "R12 reset outputs", {26'd0, a_rvalid, b_rvalid, a_misalign, b_misalign, b_spec_ack, sched_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: fill all words, adjacent words in parallel on both ports
    for (int i = 0; i < NW / 2; i++) begin
      set_a(1, 1, 2'd2, AW'((2*i) << 2), 32'h9E37_79B9 * (2*i + 1), 0);
      set_b(1, 1, 2'd2, AW'((2*i + 1) << 2), 32'h7F4A_7C15 * (2*i + 2), 0, 0);
      run_cycle(s);
      check(s, "R2 parallel write", {31'd0, s}, 32'd1);
    end
    for (int i = 0; i < NW / 2; i++) begin
      set_a(1, 0, 2'd2, AW'((2*i + 1) << 2), '0, 0);
      set_b(1, 0, 2'd2, AW'((2*i) << 2), '0, 0, 0);
      run_cycle(s);
    end
    // R1: last word through port B
    idle();
    set_b(1, 0, 2'd2, 9'h1FC, '0, 0, 0);
    run_cycle(s);
    check(b_rdata === 32'h7F4A_7C15 * 128, "R1 last word", b_rdata, 32'h7F4A_7C15 * 128);

    // R3: same bank (words 0 and 8) -> B stalls, then served
    set_a(1, 0, 2'd2, 9'h000, '0, 0);
    set_b(1, 0, 2'd2, 9'h020, '0, 0, 0);
    run_cycle(s);
    check(!s, "R3 stall", {31'd0, s}, 32'd0);
    set_a(0, 0, 2'd2, '0, '0, 0);
    run_cycle(s);
    check(s, "R3 retry served", {31'd0, s}, 32'd1);

    // R6/R7/R8/R5 directed
    idle();
    set_a(1, 1, 2'd2, 9'h040, 32'h1122_3344, 0); run_cycle(s);
    set_a(1, 0, 2'd0, 9'h040, '0, 1); run_cycle(s);
    check(a_rdata === 32'h11, "R7 byte0 big", a_rdata, 32'h11);
    set_a(1, 0, 2'd0, 9'h040, '0, 0); run_cycle(s);
    check(a_rdata === 32'h44, "R6 byte0 little", a_rdata, 32'h44);
    set_a(1, 0, 2'd1, 9'h040, '0, 1); run_cycle(s);
    check(a_rdata === 32'h1122, "R7 half0 big", a_rdata, 32'h1122);
    set_a(1, 0, 2'd1, 9'h042, '0, 0); run_cycle(s);
    check(a_rdata === 32'h1122, "R6 half2 little", a_rdata, 32'h1122);
    set_a(1, 1, 2'd0, 9'h040, 32'hFFFF_FFAB, 1); run_cycle(s);
    set_a(1, 0, 2'd3, 9'h040, '0, 0); run_cycle(s);
    check(a_rdata === 32'hAB22_3344, "R8 R5 byte write size3 read", a_rdata, 32'hAB22_3344);
    // R9: misaligned half write leaves the word alone
    set_a(1, 1, 2'd1, 9'h041, 32'h0000_FFFF, 0); run_cycle(s);
    check(a_misalign === 1'b1, "R9 flag", {31'd0, a_misalign}, 32'd1);
    set_a(1, 0, 2'd2, 9'h040, '0, 0); run_cycle(s);
    check(a_rdata === 32'hAB22_3344, "R9 no write", a_rdata, 32'hAB22_3344);

    // R10/R11
    idle();
    set_b(1, 0, 2'd2, 9'h040, '0, 0, 1); run_cycle(s);
    check(b_spec_ack === 1'b1, "R10 ack", {31'd0, b_spec_ack}, 32'd1);
    set_a(1, 0, 2'd2, 9'h040, '0, 0);
    set_b(1, 1, 2'd2, 9'h040, 32'hDEAD_BEEF, 0, 1); run_cycle(s);
    check(sched_err === 1'b1, "R11 err", {31'd0, sched_err}, 32'd1);
    check(a_rdata === 32'hAB22_3344, "R11 port A intact", a_rdata, 32'hAB22_3344);
    idle();
    set_a(1, 0, 2'd2, 9'h040, '0, 0); run_cycle(s);
    check(a_rdata === 32'hAB22_3344, "R10 no bank write", a_rdata, 32'hAB22_3344);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] aa, ba;
      logic [1:0] asz, bsz;
      aa = AW'($urandom); ba = AW'($urandom);
      asz = 2'($urandom); bsz = 2'($urandom);
      if ($urandom % 4 != 0) begin
        if (asz == 2'd1) aa[0] = 1'b0; else if (asz[1]) aa[1:0] = 2'b00;
        if (bsz == 2'd1) ba[0] = 1'b0; else if (bsz[1]) ba[1:0] = 2'b00;
      end
      set_a(($urandom % 5) != 0, $urandom % 2, asz, aa, $urandom, $urandom % 2);
      set_b(($urandom % 5) != 0, $urandom % 2, bsz, ba, $urandom, $urandom % 2, ($urandom % 20) == 0);
      run_cycle(s);
      if (b_valid && !b_special && !s) begin
        set_a(0, 0, 2'd2, '0, '0, 0);
        run_cycle(s);
        check(s, "R3 random retry", {31'd0, s}, 32'd1);
      end
    end
    idle();
    summary();
  end
endmodule